// File: doc/BRIEF.md
# Crosswise 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns their 8-bit product in the same cycle. It has no clock and no internal state. The operands are split into 2-bit halves. Four 2x2 crosswise cells, each built from AND terms and two half adders, form every half-by-half product. Three 4-bit ripple-carry adders then combine those four small products. Each adder is a chain of full adders whose carry is picked by a 2:1 multiplexer.

The lowest two product bits come straight from the low-by-low cell. The first merge adder sums the two cross-half products. The second merge adder adds the upper bits of the low-by-low product, zero-extended, to that sum. The carries of those two adders are combined and passed into the third adder. The third adder adds the high-by-high cell result and produces the top nibble of the product. A parameter selects how the full-adder carry is built, either as a mux or as an AND-OR gate.

Top module: `utm_mul4`

## Requirements
- R1: For every unsigned pair of 4-bit operands, the 8-bit output equals the arithmetic product of the two operands.
- R2: Output bit 0 equals the AND of the two operand bit 0s for every input pair.
- R3: The largest output value is 225 (both operands 15). The carry out of the third merge adder is never set.
- R4: Each 2x2 crosswise cell returns the 4-bit product of its two 2-bit inputs. Its largest value is 9.
- R5: If either operand is zero, the output is zero.
- R6: Each full adder returns sum and carry such that carry*2+sum equals the count of ones on its three inputs.
- R7: Each ripple-carry adder returns carry*16+sum equal to x+y+carry_in for its 4-bit operands.
- R8: The carries out of the first and second merge adders are never both set.
- R9: If one operand is 1, the output equals the other operand, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Unsigned multiplicand |
| b_i | input | 4 | Unsigned multiplier |
| prod_o | output | 8 | Unsigned product a_i times b_i |

## Verification
The bench first sweeps all 256 operand pairs. This separates a wrong AND term or a misrouted cell in any one of the four half-by-half positions from a correct design. Directed cases follow. Operands of 15 drive every carry path at once, including the combined carry into the third adder. Zero operands expose any stray constant, and unit operands expose any mixing of the halves. A seeded random stream from $urandom then repeats the product and bit-0 checks in an order unlike the sweep. This catches a result that only looks right because of the previous input pair.

// File: rtl/utm_pkg.sv
package utm_pkg;
   typedef enum logic [0:0] {
      FA_MUX  = 1'b0,
      FA_GATE = 1'b1
   } fa_style_e;

   localparam int unsigned CELL_W = 2;
endpackage

// File: rtl/utm_fa.sv
module utm_fa
   import utm_pkg::*;
#(
   parameter fa_style_e STYLE = FA_MUX
) (
   input  logic a_i,
   input  logic b_i,
   input  logic ci_i,
   output logic s_o,
   output logic co_o
);
   logic prop;

   assign prop = a_i ^ b_i;
   assign s_o  = prop ^ ci_i;

   generate
      if (STYLE == FA_MUX) begin : g_mux
         assign co_o = prop ? ci_i : a_i;
      end else begin : g_gate
         assign co_o = (a_i & b_i) | (prop & ci_i);
      end
   endgenerate

   // R6: counted ones on the inputs match the two output bits
   always_comb begin
      if (!$isunknown({a_i, b_i, ci_i, s_o, co_o})) begin
         a_r6_fa_count: assert ({co_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {1'b0, ci_i}))
            else $error("full adder count mismatch");
      end
   end
endmodule

// File: rtl/utm_rca.sv
module utm_rca
   import utm_pkg::*;
#(
   parameter int unsigned W     = 4,
   parameter fa_style_e   STYLE = FA_MUX
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         ci_i,
   output logic [W-1:0] s_o,
   output logic         co_o
);
   localparam int unsigned CHAIN = W + 1;

   logic [CHAIN-1:0] carry;

   if (W < 1) begin : g_bad_w
      $error("utm_rca: W must be at least 1");
   end

   assign carry[0] = ci_i;

   for (genvar k = 0; k < W; k++) begin : g_stage
      utm_fa #(.STYLE(STYLE)) fa_i (
         .a_i  (x_i[k]),
         .b_i  (y_i[k]),
         .ci_i (carry[k]),
         .s_o  (s_o[k]),
         .co_o (carry[k+1])
      );
   end

   assign co_o = carry[W];

   // R7: chain result equals the arithmetic sum
   always_comb begin
      if (!$isunknown({x_i, y_i, ci_i, s_o, co_o})) begin
         a_r7_rca_sum: assert ({co_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i}))
            else $error("ripple adder sum mismatch");
      end
   end
endmodule

// File: rtl/utm_cross2.sv
module utm_cross2
   import utm_pkg::*;
(
   input  logic [CELL_W-1:0]   a_i,
   input  logic [CELL_W-1:0]   b_i,
   output logic [2*CELL_W-1:0] p_o
);
   logic term_lo;
   logic term_x0;
   logic term_x1;
   logic term_hi;
   logic mid_s;
   logic mid_c;
   logic top_s;
   logic top_c;

   if (CELL_W != 2) begin : g_bad_cell
      $error("utm_cross2: cell width must be 2");
   end

   assign term_lo = a_i[0] & b_i[0];
   assign term_x0 = a_i[1] & b_i[0];
   assign term_x1 = a_i[0] & b_i[1];
   assign term_hi = a_i[1] & b_i[1];

   // first half adder: the crosswise pair
   assign mid_s = term_x0 ^ term_x1;
   assign mid_c = term_x0 & term_x1;

   // second half adder: the carry plus the vertical high term
   assign top_s = mid_c ^ term_hi;
   assign top_c = mid_c & term_hi;

   assign p_o = {top_c, top_s, mid_s, term_lo};

   // R4: cell output equals the 2-bit product and never exceeds 9
   always_comb begin
      if (!$isunknown({a_i, b_i, p_o})) begin
         a_r4_cell_prod: assert (p_o == ({2'b00, a_i} * {2'b00, b_i}))
            else $error("crosswise cell product mismatch");
         a_r4_cell_max: assert (p_o <= 4'd9)
            else $error("crosswise cell above 9");
      end
   end
endmodule

// File: rtl/utm_mul4.sv
module utm_mul4
   import utm_pkg::*;
#(
   parameter int unsigned OP_W     = 4,
   parameter fa_style_e   FA_STYLE = FA_MUX
) (
   input  logic [OP_W-1:0]   a_i,
   input  logic [OP_W-1:0]   b_i,
   output logic [2*OP_W-1:0] prod_o
);
   localparam int unsigned HALF_W = OP_W / 2;
   localparam int unsigned PP_W   = 2 * HALF_W;
   localparam int unsigned PROD_W = 2 * OP_W;
   localparam int unsigned N_CELL = 4;

   if (OP_W != 4) begin : g_bad_op
      $error("utm_mul4: OP_W must be 4");
   end
   if (HALF_W != CELL_W) begin : g_bad_half
      $error("utm_mul4: operand halves must match the cell width");
   end

   // cell index bit0 picks the half of a, bit1 picks the half of b
   logic [PP_W-1:0] pp [N_CELL];

   for (genvar c = 0; c < N_CELL; c++) begin : g_cell
      localparam int unsigned A_OFS = (c % 2) * HALF_W;
      localparam int unsigned B_OFS = (c / 2) * HALF_W;
      utm_cross2 cell_i (
         .a_i (a_i[A_OFS +: HALF_W]),
         .b_i (b_i[B_OFS +: HALF_W]),
         .p_o (pp[c])
      );
   end

   logic [PP_W-1:0] sum_x;
   logic            cy_x;
   logic [PP_W-1:0] sum_m;
   logic            cy_m;
   logic [PP_W-1:0] sum_h;
   logic            cy_h;
   logic            cy_acc;
   logic [PP_W-1:0] low_hi_ext;
   logic [PP_W-1:0] mid_upper;

   // first merge: the two cross-half products
   utm_rca #(.W(PP_W), .STYLE(FA_STYLE)) rca_cross_i (
      .x_i  (pp[1]),
      .y_i  (pp[2]),
      .ci_i (1'b0),
      .s_o  (sum_x),
      .co_o (cy_x)
   );

   // second merge: add the upper half of the low-by-low product
   assign low_hi_ext = {{(PP_W-HALF_W){1'b0}}, pp[0][PP_W-1 -: HALF_W]};

   utm_rca #(.W(PP_W), .STYLE(FA_STYLE)) rca_mid_i (
      .x_i  (sum_x),
      .y_i  (low_hi_ext),
      .ci_i (1'b0),
      .s_o  (sum_m),
      .co_o (cy_m)
   );

   // the two carries are mutually exclusive, so one OR accumulates them
   assign cy_acc    = cy_x | cy_m;
   assign mid_upper = {{(PP_W-HALF_W-1){1'b0}}, cy_acc, sum_m[PP_W-1 -: HALF_W]};

   // third merge: high-by-high product plus the carried middle
   utm_rca #(.W(PP_W), .STYLE(FA_STYLE)) rca_high_i (
      .x_i  (pp[3]),
      .y_i  (mid_upper),
      .ci_i (1'b0),
      .s_o  (sum_h),
      .co_o (cy_h)
   );

   assign prod_o = {sum_h, sum_m[HALF_W-1:0], pp[0][HALF_W-1:0]};

   always_comb begin
      if (!$isunknown({a_i, b_i, prod_o, cy_x, cy_m, cy_h})) begin
         // R1: full product
         a_r1_product: assert (prod_o == ({{OP_W{1'b0}}, a_i} * {{OP_W{1'b0}}, b_i}))
            else $error("product mismatch");
         // R2: bit 0 bypasses every adder
         a_r2_bit0: assert (prod_o[0] == (a_i[0] & b_i[0]))
            else $error("product bit 0 mismatch");
         // R3: no carry escapes the top adder, result bounded by 225
         a_r3_no_overflow: assert (!cy_h && (prod_o <= PROD_W'(225)))
            else $error("top adder overflow");
         // R8: the first two merge carries never coincide
         a_r8_carry_excl: assert (!(cy_x && cy_m))
            else $error("merge carries both set");
      end
   end
endmodule

// File: tb/utm_mul4_tb_top.sv
module utm_mul4_tb_top;
   logic       clk;
   logic       rst;
   logic [3:0] a;
   logic [3:0] b;
   logic [7:0] prod;

   int n_checks;
   int n_errors;
   bit done;

   utm_mul4 dut_i (
      .a_i    (a),
      .b_i    (b),
      .prod_o (prod)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   // shift-and-add reference, independent of the crosswise structure
   function automatic int ref_mul(input int x, input int y);
      int acc;
      acc = 0;
      for (int k = 0; k < 4; k++) begin
         if (((y >> k) & 1) != 0) acc = acc + (x << k);
      end
      return acc;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
      end
   endtask

   task automatic apply(input int x, input int y);
      @(negedge clk);
      a = x[3:0];
      b = y[3:0];
      #2;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int seed;
      int ra;
      int rb;
      n_checks = 0;
      n_errors = 0;
      done     = 1'b0;
      rst      = 1'b1;
      a        = '0;
      b        = '0;
      repeat (3) @(posedge clk);
      #2;
      check("R5 reset-state zero", int'(prod), 0);
      rst = 1'b0;

      // exhaustive sweep: R1 product, R2 bit 0
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            apply(x, y);
            check("R1", int'(prod), ref_mul(x, y));
            check("R2", int'(prod[0]), (x & y) & 1);
         end
      end

      // R3: maximum value
      apply(15, 15);
      check("R3 max", int'(prod), 225);
      // R4: each cell position saturated at 9 in isolation
      apply(3, 3);
      check("R4 low-low cell", int'(prod), 9);
      apply(12, 3);
      check("R4 high-low cell", int'(prod), 36);
      apply(3, 12);
      check("R4 low-high cell", int'(prod), 36);
      apply(12, 12);
      check("R4 high-high cell", int'(prod), 144);
      // R5: zero operand
      apply(0, 13);
      check("R5", int'(prod), 0);
      apply(11, 0);
      check("R5", int'(prod), 0);
      // R9: unit operand
      apply(1, 14);
      check("R9", int'(prod), 14);
      apply(13, 1);
      check("R9", int'(prod), 13);
      // R6 R7 R8: carry-heavy merges
      apply(15, 14);
      check("R6 R7 carry chain", int'(prod), 210);
      apply(14, 15);
      check("R8 merge carries", int'(prod), 210);

      // seeded random stream
      seed = 7;
      ra = $urandom(seed);
      for (int n = 0; n < 400; n++) begin
         ra = int'($urandom_range(15, 0));
         rb = int'($urandom_range(15, 0));
         apply(ra, rb);
         check("R1 random", int'(prod), ref_mul(ra, rb));
         check("R2 random", int'(prod[0]), (ra & rb) & 1);
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule